// File: doc/BRIEF.md
# Hardware Stack Pointer Unit

This block keeps the 16-bit stack pointer of an 8-bit core whose stack sits in data SRAM and grows downward. Software sees the pointer as two byte-wide registers in I/O space and can read or load either one at any time. The core drives four operation strobes: single-byte push, single-byte pop, return-address push (call or interrupt entry) and return-address pop (subroutine or interrupt return). For each one the unit produces the SRAM address, the write data or read enable, and moves the pointer.

Pushes store at the current pointer and then step it down. Pops step it up first and then read. A return address takes two SRAM cycles. The low byte goes to the current pointer and the high byte to the location one below it. A pop reads them back in the opposite order, and bit 15 of the recovered address is forced to zero. A small state machine has three states. ST_IDLE accepts strobes. ST_RPUSH_HI writes the high byte of a return address. ST_RPOP_LO reads the low byte of a return address. The transitions are: IDLE to RPUSH_HI on a return push, IDLE to RPOP_LO on a return pop, and both of those back to IDLE after one cycle. Byte operations stay in IDLE.

Top module: `spu_top`

## Requirements
- R1: After reset both pointer bytes read 0, `busy` is low and neither `pop_valid` nor `ret_valid` is asserted.
- R2: An I/O write with `io_addr` = 0x3D loads pointer bits 7:0, and one with `io_addr` = 0x3E loads bits 15:8. `io_rdata` returns those bytes at those addresses and returns 0 at any other address.
- R3: A byte push writes `push_data` at the current pointer in the strobe cycle, and the pointer then drops by 1.
- R4: A byte pop reads the address pointer+1 in the strobe cycle and the pointer rises by 1. The byte read appears on `pop_data` with `pop_valid` high for the one cycle after the strobe edge.
- R5: A return push writes `ret_in[7:0]` at pointer P in the strobe cycle and `ret_in[15:8]` at P-1 in the following cycle, during which `busy` is high. The pointer ends at P-2.
- R6: A return pop reads the high byte at P+1 and then the low byte at P+2, and the pointer ends at P+2. `ret_out` then shows the address with bit 15 cleared, with `ret_valid` high for one cycle.
- R7: When an I/O pointer write and a stack operation share a cycle, the pointer takes the written value. The SRAM access of that operation still takes place.
- R8: Operation strobes are ignored while `busy` is high.
- R9: Simultaneous strobes in ST_IDLE are resolved in this order: return push, return pop, byte push, byte pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_wr_en | input | 1 | I/O write strobe |
| io_addr | input | 6 | I/O register address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data for io_addr |
| op_push_byte | input | 1 | Byte push strobe |
| op_pop_byte | input | 1 | Byte pop strobe |
| op_push_ret | input | 1 | Return-address push strobe |
| op_pop_ret | input | 1 | Return-address pop strobe |
| push_data | input | 8 | Byte to push |
| ret_in | input | 16 | Return address to push |
| mem_addr | output | 16 | SRAM address |
| mem_we | output | 1 | SRAM write enable |
| mem_re | output | 1 | SRAM read enable |
| mem_wdata | output | 8 | SRAM write data |
| mem_rdata | input | 8 | SRAM read data, same cycle as mem_re |
| pop_data | output | 8 | Popped byte |
| pop_valid | output | 1 | pop_data valid |
| ret_out | output | 16 | Popped return address, bit 15 cleared |
| ret_valid | output | 1 | ret_out valid |
| busy | output | 1 | Second cycle of a return operation |

## Verification
The bench uses the defaults: an 8-bit byte width (giving a 16-bit pointer), I/O addresses 0x3D and 0x3E, and 15 kept return-address bits. With these values a pushed return address with bit 15 set comes back masked. The 0x0F00 region of a 4 KB modelled SRAM lets the bench check the placement of every byte and the pointer arithmetic across stacked byte and return frames. The 15-bit mask also makes the high-byte masking visible at the ports.

// File: rtl/spu_pkg.sv
package spu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RPUSH_HI = 2'd1,
        ST_RPOP_LO  = 2'd2
    } spu_state_t;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_DEC  = 2'd1,
        STEP_INC  = 2'd2
    } spu_step_t;
endpackage

// File: rtl/spu_pointer.sv
module spu_pointer
    import spu_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int PW    = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    input  spu_step_t         step,
    output logic [PW-1:0]     sp
);
    // software load wins over any step in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) sp[BYTE_W-1:0]  <= wdata;
            if (wr_hi) sp[PW-1:BYTE_W] <= wdata;
        end else begin
            unique case (step)
                STEP_DEC:  sp <= sp - PW'(1);
                STEP_INC:  sp <= sp + PW'(1);
                default:   sp <= sp;
            endcase
        end
    end
endmodule

// File: rtl/spu_ctrl.sv
module spu_ctrl
    import spu_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int RET_BITS = 15,
    localparam int PW      = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_push_byte,
    input  logic              op_pop_byte,
    input  logic              op_push_ret,
    input  logic              op_pop_ret,
    input  logic [BYTE_W-1:0] push_data,
    input  logic [PW-1:0]     ret_in,
    input  logic [PW-1:0]     sp,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [PW-1:0]     mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [BYTE_W-1:0] mem_wdata,
    output spu_step_t         step,
    output logic [BYTE_W-1:0] pop_data,
    output logic              pop_valid,
    output logic [PW-1:0]     ret_out,
    output logic              ret_valid,
    output logic              busy
);
    localparam logic [PW-1:0] RET_MASK = PW'((64'd1 << RET_BITS) - 64'd1);

    spu_state_t        state, state_nxt;
    logic [BYTE_W-1:0] hi_hold;
    logic              cap_byte, cap_hi, fin_ret, load_hi;

    always_comb begin
        state_nxt = state;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = sp;
        mem_wdata = '0;
        step      = STEP_HOLD;
        cap_byte  = 1'b0;
        cap_hi    = 1'b0;
        fin_ret   = 1'b0;
        load_hi   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (op_push_ret) begin
                    mem_we    = 1'b1;
                    mem_wdata = ret_in[BYTE_W-1:0];
                    step      = STEP_DEC;
                    load_hi   = 1'b1;
                    state_nxt = ST_RPUSH_HI;
                end else if (op_pop_ret) begin
                    mem_re    = 1'b1;
                    mem_addr  = sp + PW'(1);
                    step      = STEP_INC;
                    cap_hi    = 1'b1;
                    state_nxt = ST_RPOP_LO;
                end else if (op_push_byte) begin
                    mem_we    = 1'b1;
                    mem_wdata = push_data;
                    step      = STEP_DEC;
                end else if (op_pop_byte) begin
                    mem_re    = 1'b1;
                    mem_addr  = sp + PW'(1);
                    step      = STEP_INC;
                    cap_byte  = 1'b1;
                end
            end
            ST_RPUSH_HI: begin
                mem_we    = 1'b1;
                mem_wdata = hi_hold;
                step      = STEP_DEC;
                state_nxt = ST_IDLE;
            end
            ST_RPOP_LO: begin
                mem_re    = 1'b1;
                mem_addr  = sp + PW'(1);
                step      = STEP_INC;
                fin_ret   = 1'b1;
                state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_hold   <= '0;
            pop_data  <= '0;
            pop_valid <= 1'b0;
            ret_out   <= '0;
            ret_valid <= 1'b0;
        end else begin
            if (load_hi)  hi_hold  <= ret_in[PW-1:BYTE_W];
            if (cap_hi)   hi_hold  <= mem_rdata;
            if (cap_byte) pop_data <= mem_rdata;
            if (fin_ret)  ret_out  <= {hi_hold, mem_rdata} & RET_MASK;
            pop_valid <= cap_byte;
            ret_valid <= fin_ret;
        end
    end

    assign busy = (state != ST_IDLE);

    // R8: each return operation holds the unit for exactly one extra cycle
    a_r8_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
    // R6: a return result only follows the low-byte read cycle
    a_r6_ret_after_low_read: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> ($past(state) == ST_RPOP_LO));
    // R4: a popped byte only follows a read
    a_r4_pop_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |-> $past(mem_re));
    // R5: never a read and a write to SRAM in the same cycle
    a_r5_access_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));
endmodule

// File: rtl/spu_top.sv
module spu_top
    import spu_pkg::*;
#(
    parameter int              BYTE_W   = 8,
    parameter int              IO_AW    = 6,
    parameter logic [IO_AW-1:0] IO_LO   = 6'h3D,
    parameter logic [IO_AW-1:0] IO_HI   = 6'h3E,
    parameter int              RET_BITS = 15,
    localparam int             PW       = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr_en,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [BYTE_W-1:0] io_wdata,
    output logic [BYTE_W-1:0] io_rdata,
    input  logic              op_push_byte,
    input  logic              op_pop_byte,
    input  logic              op_push_ret,
    input  logic              op_pop_ret,
    input  logic [BYTE_W-1:0] push_data,
    input  logic [PW-1:0]     ret_in,
    output logic [PW-1:0]     mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [BYTE_W-1:0] pop_data,
    output logic              pop_valid,
    output logic [PW-1:0]     ret_out,
    output logic              ret_valid,
    output logic              busy
);
    logic [PW-1:0] sp;
    spu_step_t     step;
    logic          wr_lo, wr_hi;

    assign wr_lo = io_wr_en && (io_addr == IO_LO);
    assign wr_hi = io_wr_en && (io_addr == IO_HI);

    always_comb begin
        if (io_addr == IO_LO)      io_rdata = sp[BYTE_W-1:0];
        else if (io_addr == IO_HI) io_rdata = sp[PW-1:BYTE_W];
        else                       io_rdata = '0;
    end

    spu_pointer #(.BYTE_W(BYTE_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_lo (wr_lo),
        .wr_hi (wr_hi),
        .wdata (io_wdata),
        .step  (step),
        .sp    (sp)
    );

    spu_ctrl #(.BYTE_W(BYTE_W), .RET_BITS(RET_BITS)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_push_byte (op_push_byte),
        .op_pop_byte  (op_pop_byte),
        .op_push_ret  (op_push_ret),
        .op_pop_ret   (op_pop_ret),
        .push_data    (push_data),
        .ret_in       (ret_in),
        .sp           (sp),
        .mem_rdata    (mem_rdata),
        .mem_addr     (mem_addr),
        .mem_we       (mem_we),
        .mem_re       (mem_re),
        .mem_wdata    (mem_wdata),
        .step         (step),
        .pop_data     (pop_data),
        .pop_valid    (pop_valid),
        .ret_out      (ret_out),
        .ret_valid    (ret_valid),
        .busy         (busy)
    );

    // R3: a write access without a software load lowers the pointer by one
    a_r3_write_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !io_wr_en) |=> (sp == $past(sp) - PW'(1)));
    // R4: a read access without a software load raises the pointer by one
    a_r4_read_steps_up: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && !io_wr_en) |=> (sp == $past(sp) + PW'(1)));
    // R7: a software load of the low byte lands regardless of stack activity
    a_r7_sw_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (sp[BYTE_W-1:0] == $past(io_wdata)));
endmodule

// File: tb/spu_top_tb.sv
`timescale 1ns/100ps
module spu_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr_en = 1'b0;
    logic [5:0]  io_addr = 6'h00;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic        op_push_byte = 1'b0, op_pop_byte = 1'b0;
    logic        op_push_ret = 1'b0, op_pop_ret = 1'b0;
    logic [7:0]  push_data = 8'h00;
    logic [15:0] ret_in = 16'h0000;
    logic [15:0] mem_addr;
    logic        mem_we, mem_re;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [7:0]  pop_data;
    logic        pop_valid;
    logic [15:0] ret_out;
    logic        ret_valid;
    logic        busy;

    logic [7:0]  ram [0:4095];
    logic [7:0]  byte_q[$];
    logic [15:0] ret_q[$];
    logic [15:0] exp_sp;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    spu_top u_dut (
        .clk(clk), .rst_n(rst_n), .io_wr_en(io_wr_en), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .op_push_byte(op_push_byte),
        .op_pop_byte(op_pop_byte), .op_push_ret(op_push_ret), .op_pop_ret(op_pop_ret),
        .push_data(push_data), .ret_in(ret_in), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .pop_data(pop_data), .pop_valid(pop_valid), .ret_out(ret_out),
        .ret_valid(ret_valid), .busy(busy)
    );

    assign mem_rdata = ram[mem_addr[11:0]];
    always @(posedge clk) if (mem_we) ram[mem_addr[11:0]] <= mem_wdata;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic read_sp(output logic [15:0] v);
        io_addr = 6'h3D; #0.2; v[7:0]  = io_rdata;
        io_addr = 6'h3E; #0.2; v[15:8] = io_rdata;
    endtask

    task automatic check_sp(input string req);
        logic [15:0] v;
        read_sp(v);
        chk(req, int'(v), int'(exp_sp));
    endtask

    task automatic sw_write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk); io_wr_en = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk); io_wr_en = 1'b0;
    endtask

    task automatic push_byte(input logic [7:0] d);
        @(negedge clk); op_push_byte = 1'b1; push_data = d;
        @(negedge clk); op_push_byte = 1'b0;
        exp_sp = exp_sp - 16'd1;
    endtask

    task automatic pop_byte(input logic [7:0] e);
        byte_q.push_back(e);
        @(negedge clk); op_pop_byte = 1'b1;
        @(negedge clk); op_pop_byte = 1'b0;
        exp_sp = exp_sp + 16'd1;
    endtask

    task automatic push_ret(input logic [15:0] v);
        @(negedge clk); op_push_ret = 1'b1; ret_in = v;
        @(negedge clk); op_push_ret = 1'b0;
        chk("R5 busy in second cycle", int'(busy), 1);
        @(negedge clk);
        exp_sp = exp_sp - 16'd2;
    endtask

    task automatic pop_ret(input logic [15:0] e);
        ret_q.push_back(e);
        @(negedge clk); op_pop_ret = 1'b1;
        @(negedge clk); op_pop_ret = 1'b0;
        @(negedge clk);
        exp_sp = exp_sp + 16'd2;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // monitor: scoreboard compare of produced results
    always @(negedge clk) begin
        if (rst_n && pop_valid) begin
            if (byte_q.size() == 0) chk("R4 unexpected pop_valid", 1, 0);
            else chk("R4 popped byte", int'(pop_data), int'(byte_q.pop_front()));
        end
        if (rst_n && ret_valid) begin
            if (ret_q.size() == 0) chk("R6 unexpected ret_valid", 1, 0);
            else chk("R6 return address", int'(ret_out), int'(ret_q.pop_front()));
        end
    end

    initial begin
        #80000;
        if (!done) begin
            chk("watchdog expired", 1, 0);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) ram[i] = 8'h00;
        exp_sp = 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check_sp("R1 pointer after reset");
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 no results after reset", int'(pop_valid | ret_valid), 0);

        // R2
        sw_write(6'h3D, 8'h80);
        sw_write(6'h3E, 8'h0F);
        exp_sp = 16'h0F80;
        check_sp("R2 pointer load and readback");
        io_addr = 6'h10; #0.2;
        chk("R2 other address reads zero", int'(io_rdata), 0);

        // R3
        push_byte(8'hA1); push_byte(8'hB2); push_byte(8'hC3);
        check_sp("R3 pointer after three pushes");
        chk("R3 first byte at start", int'(ram[12'hF80]), 8'hA1);
        chk("R3 third byte", int'(ram[12'hF7E]), 8'hC3);

        // R4
        pop_byte(8'hC3); pop_byte(8'hB2); pop_byte(8'hA1);
        @(negedge clk);
        check_sp("R4 pointer after pops");

        // R5
        push_ret(16'h9234);
        check_sp("R5 pointer after return push");
        chk("R5 low byte at P", int'(ram[12'hF80]), 8'h34);
        chk("R5 high byte at P-1", int'(ram[12'hF7F]), 8'h92);

        // R6 with bit 15 masked
        pop_ret(16'h1234);
        check_sp("R6 pointer after return pop");

        // nested frames
        push_ret(16'h0ABC);
        push_byte(8'h55);
        pop_byte(8'h55);
        pop_ret(16'h0ABC);
        @(negedge clk);
        check_sp("R6 pointer after nested frames");

        // R7: software load and push in the same cycle
        @(negedge clk); op_push_byte = 1'b1; push_data = 8'h66;
        io_wr_en = 1'b1; io_addr = 6'h3D; io_wdata = 8'h40;
        @(negedge clk); op_push_byte = 1'b0; io_wr_en = 1'b0;
        exp_sp = 16'h0F40;
        check_sp("R7 software load wins");
        chk("R7 access still made", int'(ram[12'hF80]), 8'h66);

        // R8: strobe during busy cycle ignored
        @(negedge clk); op_push_ret = 1'b1; ret_in = 16'h0102;
        @(negedge clk); op_push_ret = 1'b0; op_push_byte = 1'b1; push_data = 8'h77;
        @(negedge clk); op_push_byte = 1'b0;
        exp_sp = 16'h0F3E;
        check_sp("R8 pointer after ignored strobe");
        chk("R8 high byte not overwritten", int'(ram[12'hF3F]), 8'h01);

        // R9: byte push beats byte pop
        @(negedge clk); op_push_byte = 1'b1; op_pop_byte = 1'b1; push_data = 8'h99;
        @(negedge clk); op_push_byte = 1'b0; op_pop_byte = 1'b0;
        exp_sp = 16'h0F3D;
        check_sp("R9 push wins over pop");
        chk("R9 byte written", int'(ram[12'hF3E]), 8'h99);
        chk("R9 no pop result", int'(pop_valid), 0);

        repeat (3) @(negedge clk);
        chk("R4 R6 all expected results seen", byte_q.size() + ret_q.size(), 0);
        done = 1'b1;
        finish_run();
    end
endmodule